// File: doc/BRIEF.md
# Addressable Multi-Drop Serial Register Interface

This block is the register-access slave of a frequency-conversion chip. A host programs and reads it over a three-wire serial bus: an active-low frame enable, a serial clock and a data line. Up to four such slaves can hang off one bus without separate selects. Each slave learns its identity from two strap pins. Until software turns addressing on, every slave takes every frame. After that, a slave takes only frames that carry its own strap value. The bus pins are oversampled by the system clock through synchronisers.

A control byte at register address 0 sets the slave's behaviour. It can move read data to a dedicated output pin, giving four-wire operation. It can take the chip-enable and mode functions away from their pins, and the pins then serve as general-purpose outputs. It holds the addressing enable and a duplex setting. From the effective mode and duplex settings the block derives which mixer paths are on and which synthesizer register bank is in use. The other registers form a small generic register file.

Top module: `mdsi_slave`

## Requirements
- R1: A frame is 26 bits sent MSB first, sampled on rising serial-clock edges while `bus_en_n` is low. The bits are read flag (1 = read), 2-bit device address, 7-bit register address, then 16 data bits. A write takes effect on the 26th rising edge.
- R2: After reset, addressing is off and a slave accepts every frame whatever its device-address field.
- R3: While control bit 2 (address enable) is set, frames whose device address differs from `strap_addr` are ignored. Such writes change no register, and such reads drive no pin.
- R4: While control bit 0 (four-wire) is set, read data leaves on `bus_sdo_out` with `bus_sdo_oe`, and `bus_sdio_oe` stays low.
- R5: On a read, clock 11 is a turnaround. The slave drives D15 after the falling edge of clock 11, and the host samples D15..D0 on rising edges 12 to 27. The slave drives only when the frame is accepted, and releases the line after the falling edge of clock 27.
- R6: While control bit 1 (software control) is set, chip enable follows control bit 3 and mode follows control bit 4, and the pins are ignored. `gpo_oe` is then high, and the two freed pins output control bits 6 (enable pin) and 7 (mode pin).
- R7: With duplex (control bit 5) clear, mode 0 turns on mixer 1 with bank 0, and mode 1 turns on mixer 2 with bank 1.
- R8: With duplex set, both mixers are on and the bank still equals the mode.
- R9: `rst_n` low returns the control byte and all generic registers to zero. No data pin is driven, and all routing outputs are low.
- R10: Register addresses at or above NUM_REGS (default 8) read as zero, and writes to them are ignored. Control reads return the byte in bits 7:0 with zeros above.
- R11: A frame that ends (enable raised) before its 26th rising edge writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| strap_addr | input | 2 | Device identity straps |
| bus_en_n | input | 1 | Frame enable, active low |
| bus_sclk | input | 1 | Serial clock |
| bus_sdio_in | input | 1 | Serial data from host |
| bus_sdio_out | output | 1 | Read data on the shared data line |
| bus_sdio_oe | output | 1 | Drive enable for the shared data line |
| bus_sdo_out | output | 1 | Read data on the four-wire output |
| bus_sdo_oe | output | 1 | Drive enable for the four-wire output |
| pin_enable | input | 1 | Hardware chip-enable pin |
| pin_mode | input | 1 | Hardware mode pin |
| gpo_oe | output | 1 | Freed pins act as outputs |
| gpo_enable_pin | output | 1 | Output value for the enable pin |
| gpo_mode_pin | output | 1 | Output value for the mode pin |
| chip_enable | output | 1 | Effective chip enable |
| mix1_on | output | 1 | Mixer path 1 active |
| mix2_on | output | 1 | Mixer path 2 active |
| pll_bank | output | 1 | Active synthesizer bank (0 or 1) |

## Verification
Two things can fall into the same cycle. One is a control-byte write that commits on the 26th rising edge. The other is a change on the mode pin, which passes through its own synchroniser and reaches the routing logic at about the same clock. The bench flips `pin_mode` on exactly that rising edge while writing the duplex bit. It then judges the settled mixer and bank outputs against the combination of both new values. Address filtering is also checked across changes, with constrained-random writes from every device address tracked against a model of the accepted ones.

// File: rtl/mdsi_pkg.sv
package mdsi_pkg;

    // Control byte at register address 0; bit positions are decoded by routing
    typedef struct packed {
        logic gpo_mode;   // 7
        logic gpo_en;     // 6
        logic duplex;     // 5
        logic sw_mode;    // 4
        logic sw_enable;  // 3
        logic addr_en;    // 2
        logic sw_ctrl;    // 1
        logic four_wire;  // 0
    } ctrl_t;

    localparam int CTRL_W = 8;

    typedef struct packed {
        logic chip_en;
        logic mix1;
        logic mix2;
        logic bank;
        logic gpo_oe;
        logic gpo_en;
        logic gpo_mode;
    } route_t;

endpackage

// File: rtl/mdsi_sync.sv
module mdsi_sync #(
    parameter int              WIDTH   = 1,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/mdsi_frame.sv
module mdsi_frame #(
    parameter int DEV_AW = 2,
    parameter int REG_AW = 7,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_n_s,
    input  logic              sclk_s,
    input  logic              sdi_s,
    input  logic              four_wire,
    input  logic              addr_en,
    input  logic [DEV_AW-1:0] strap,
    input  logic [DATA_W-1:0] rd_data,
    output logic [REG_AW-1:0] rd_addr,
    output logic              wr_en,
    output logic [REG_AW-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              sdio_out,
    output logic              sdio_oe,
    output logic              sdo_out,
    output logic              sdo_oe
);
    localparam int HDR_LEN = 1 + DEV_AW + REG_AW;
    localparam int WR_LEN  = HDR_LEN + DATA_W;
    localparam int TA_BIT  = HDR_LEN + 1;
    localparam int RD_LEN  = TA_BIT + DATA_W;
    localparam int CNT_W   = $clog2(RD_LEN + 2);
    localparam logic [CNT_W-1:0] C_HDR_LAST = CNT_W'(HDR_LEN - 1);
    localparam logic [CNT_W-1:0] C_HDR      = CNT_W'(HDR_LEN);
    localparam logic [CNT_W-1:0] C_WR_LAST  = CNT_W'(WR_LEN - 1);
    localparam logic [CNT_W-1:0] C_WR       = CNT_W'(WR_LEN);
    localparam logic [CNT_W-1:0] C_TA       = CNT_W'(TA_BIT);
    localparam logic [CNT_W-1:0] C_RD       = CNT_W'(RD_LEN);

    typedef struct packed {
        logic              sclk_prev;
        logic [CNT_W-1:0]  cnt;
        logic [HDR_LEN-2:0] hdr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rshift;
        logic              is_read;
        logic              sel;
        logic              drive;
        logic              dout;
        logic              wr_en;
    } fr_t;

    fr_t fr_d, fr_q;
    logic [HDR_LEN-1:0] hdr_full;
    logic [DEV_AW-1:0]  dev_field;
    logic               rise, fall;

    always_comb begin
        hdr_full  = {fr_q.hdr, sdi_s};
        dev_field = hdr_full[HDR_LEN-2 -: DEV_AW];
        rise      = sclk_s & ~fr_q.sclk_prev;
        fall      = ~sclk_s & fr_q.sclk_prev;

        fr_d           = fr_q;
        fr_d.sclk_prev = sclk_s;
        fr_d.wr_en     = 1'b0;

        if (en_n_s) begin
            fr_d.cnt     = '0;
            fr_d.drive   = 1'b0;
            fr_d.is_read = 1'b0;
            fr_d.sel     = 1'b0;
        end else begin
            if (rise) begin
                if (fr_q.cnt != '1) fr_d.cnt = fr_q.cnt + 1'b1;
                if (fr_q.cnt < C_HDR) begin
                    fr_d.hdr = hdr_full[HDR_LEN-2:0];
                end else if (fr_q.cnt < C_WR) begin
                    fr_d.wdata = {fr_q.wdata[DATA_W-2:0], sdi_s};
                end
                if (fr_q.cnt == C_HDR_LAST) begin
                    fr_d.is_read = hdr_full[HDR_LEN-1];
                    fr_d.sel     = ~addr_en | (dev_field == strap);
                    fr_d.rshift  = rd_data;
                end
                if (fr_q.cnt == C_WR_LAST && !fr_q.is_read && fr_q.sel) begin
                    fr_d.wr_en = 1'b1;
                end
            end
            if (fall) begin
                if (fr_q.cnt >= C_TA && fr_q.cnt < C_RD && fr_q.is_read && fr_q.sel) begin
                    fr_d.drive  = 1'b1;
                    fr_d.dout   = fr_q.rshift[DATA_W-1];
                    fr_d.rshift = {fr_q.rshift[DATA_W-2:0], 1'b0};
                end else begin
                    fr_d.drive = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fr_q <= '0;
        else        fr_q <= fr_d;
    end

    assign rd_addr  = hdr_full[REG_AW-1:0];
    assign wr_en    = fr_q.wr_en;
    assign wr_addr  = fr_q.hdr[REG_AW-1:0];
    assign wr_data  = fr_q.wdata;
    assign sdio_out = fr_q.dout;
    assign sdo_out  = fr_q.dout;
    assign sdio_oe  = fr_q.drive & ~four_wire;
    assign sdo_oe   = fr_q.drive & four_wire;

    AST_DRIVE_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        fr_q.drive |-> $past(!en_n_s)) else $error("drive outside frame"); // R5
    AST_WRITE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        fr_q.wr_en |-> ($past(fr_q.cnt) == C_WR_LAST)) else $error("early write"); // R1
    AST_NO_WRITE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        fr_q.wr_en |-> !$past(fr_q.is_read)) else $error("write during read"); // R5
endmodule

// File: rtl/mdsi_regs.sv
module mdsi_regs #(
    parameter int REG_AW   = 7,
    parameter int DATA_W   = 16,
    parameter int NUM_REGS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [REG_AW-1:0]    wr_addr,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic [REG_AW-1:0]    rd_addr,
    output logic [DATA_W-1:0]    rd_data,
    output mdsi_pkg::ctrl_t      ctrl
);
    import mdsi_pkg::*;
    localparam int GEN_N = NUM_REGS - 1;

    typedef struct packed {
        ctrl_t                          ctrl;
        logic [GEN_N-1:0][DATA_W-1:0]   gen;
    } rg_t;

    rg_t rg_d, rg_q;

    always_comb begin
        rg_d = rg_q;
        if (wr_en) begin
            if (wr_addr == '0) rg_d.ctrl = ctrl_t'(wr_data[CTRL_W-1:0]);
            for (int i = 0; i < GEN_N; i++) begin
                if (wr_addr == REG_AW'(i + 1)) rg_d.gen[i] = wr_data;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == '0) rd_data = DATA_W'(rg_q.ctrl);
        for (int i = 0; i < GEN_N; i++) begin
            if (rd_addr == REG_AW'(i + 1)) rd_data = rg_q.gen[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end

    assign ctrl = rg_q.ctrl;

    AST_CTRL_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rg_q.ctrl) |-> $past(wr_en && wr_addr == '0)) else $error("ctrl changed"); // R11
endmodule

// File: rtl/mdsi_route.sv
module mdsi_route (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_enable_s,
    input  logic             pin_mode_s,
    input  mdsi_pkg::ctrl_t  ctrl,
    output mdsi_pkg::route_t rt
);
    import mdsi_pkg::*;
    route_t rt_d, rt_q;
    logic   mode_eff, en_eff;

    always_comb begin
        mode_eff       = ctrl.sw_ctrl ? ctrl.sw_mode   : pin_mode_s;
        en_eff         = ctrl.sw_ctrl ? ctrl.sw_enable : pin_enable_s;
        rt_d.chip_en   = en_eff;
        rt_d.bank      = mode_eff;
        rt_d.mix1      = ctrl.duplex | ~mode_eff;
        rt_d.mix2      = ctrl.duplex | mode_eff;
        rt_d.gpo_oe    = ctrl.sw_ctrl;
        rt_d.gpo_en    = ctrl.sw_ctrl & ctrl.gpo_en;
        rt_d.gpo_mode  = ctrl.sw_ctrl & ctrl.gpo_mode;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rt_q <= '0;
        else        rt_q <= rt_d;
    end

    assign rt = rt_q;

    AST_BOTH_MIX_NEEDS_DUPLEX: assert property (@(posedge clk) disable iff (!rst_n)
        (rt_q.mix1 && rt_q.mix2) |-> $past(ctrl.duplex)) else $error("both mixers"); // R8
    AST_GPO_NEEDS_SW: assert property (@(posedge clk) disable iff (!rst_n)
        rt_q.gpo_oe |-> $past(ctrl.sw_ctrl)) else $error("gpo without sw"); // R6
endmodule

// File: rtl/mdsi_slave.sv
module mdsi_slave #(
    parameter int DEV_AW      = 2,
    parameter int REG_AW      = 7,
    parameter int DATA_W      = 16,
    parameter int NUM_REGS    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DEV_AW-1:0] strap_addr,
    input  logic              bus_en_n,
    input  logic              bus_sclk,
    input  logic              bus_sdio_in,
    output logic              bus_sdio_out,
    output logic              bus_sdio_oe,
    output logic              bus_sdo_out,
    output logic              bus_sdo_oe,
    input  logic              pin_enable,
    input  logic              pin_mode,
    output logic              gpo_oe,
    output logic              gpo_enable_pin,
    output logic              gpo_mode_pin,
    output logic              chip_enable,
    output logic              mix1_on,
    output logic              mix2_on,
    output logic              pll_bank
);
    import mdsi_pkg::*;
    localparam int SYNC_W = 5;

    logic [SYNC_W-1:0] raw_in, sync_out;
    logic [REG_AW-1:0] rd_addr, wr_addr;
    logic [DATA_W-1:0] rd_data, wr_data;
    logic              wr_en;
    ctrl_t             ctrl;
    route_t            rt;

    assign raw_in = {bus_en_n, bus_sclk, bus_sdio_in, pin_enable, pin_mode};

    mdsi_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES), .RST_VAL(5'b10000)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(raw_in), .dout(sync_out)
    );

    mdsi_frame #(.DEV_AW(DEV_AW), .REG_AW(REG_AW), .DATA_W(DATA_W)) u_frame (
        .clk(clk), .rst_n(rst_n),
        .en_n_s(sync_out[4]), .sclk_s(sync_out[3]), .sdi_s(sync_out[2]),
        .four_wire(ctrl.four_wire), .addr_en(ctrl.addr_en), .strap(strap_addr),
        .rd_data(rd_data), .rd_addr(rd_addr),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .sdio_out(bus_sdio_out), .sdio_oe(bus_sdio_oe),
        .sdo_out(bus_sdo_out), .sdo_oe(bus_sdo_oe)
    );

    mdsi_regs #(.REG_AW(REG_AW), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .ctrl(ctrl)
    );

    mdsi_route u_route (
        .clk(clk), .rst_n(rst_n),
        .pin_enable_s(sync_out[1]), .pin_mode_s(sync_out[0]),
        .ctrl(ctrl), .rt(rt)
    );

    assign gpo_oe         = rt.gpo_oe;
    assign gpo_enable_pin = rt.gpo_en;
    assign gpo_mode_pin   = rt.gpo_mode;
    assign chip_enable    = rt.chip_en;
    assign mix1_on        = rt.mix1;
    assign mix2_on        = rt.mix2;
    assign pll_bank       = rt.bank;
endmodule

// File: tb/mdsi_slave_test.sv
`timescale 1ns/1ps
module mdsi_slave_test;
    localparam int HALF = 8;
    localparam logic [1:0] STRAP = 2'd2;

    logic clk = 1'b0;
    logic rst_n, en_n, sclk, sdi, pin_enable, pin_mode;
    logic [1:0] strap;
    logic sdio_out, sdio_oe, sdo_out, sdo_oe;
    logic gpo_oe, gpo_en_pin, gpo_mode_pin, chip_en, mix1, mix2, bank;

    int checks = 0, failures = 0;
    bit done = 0;
    logic [15:0] rd_word;
    int drv_sdio, drv_sdo;
    logic [15:0] model [1:7];

    always #4 clk = ~clk;

    mdsi_slave uut (
        .clk(clk), .rst_n(rst_n), .strap_addr(strap),
        .bus_en_n(en_n), .bus_sclk(sclk), .bus_sdio_in(sdi),
        .bus_sdio_out(sdio_out), .bus_sdio_oe(sdio_oe),
        .bus_sdo_out(sdo_out), .bus_sdo_oe(sdo_oe),
        .pin_enable(pin_enable), .pin_mode(pin_mode),
        .gpo_oe(gpo_oe), .gpo_enable_pin(gpo_en_pin), .gpo_mode_pin(gpo_mode_pin),
        .chip_enable(chip_en), .mix1_on(mix1), .mix2_on(mix2), .pll_bank(bank)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [2:0] exp_route(input logic mode, input logic dup);
        return dup ? {1'b1, 1'b1, mode} : {~mode, mode, mode};
    endfunction

    task automatic xfer(input logic rw, input logic [1:0] dev, input logic [6:0] ra,
                        input logic [15:0] wd, input int nbits, input int toggle_at);
        logic [25:0] word;
        word = {rw, dev, ra, wd};
        rd_word = '0; drv_sdio = 0; drv_sdo = 0;
        @(negedge clk); en_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 1; i <= nbits; i++) begin
            sdi = (i <= 26 && !(rw && i > 10)) ? word[26-i] : 1'b0;
            for (int k = 0; k < HALF; k++) begin
                @(negedge clk);
                drv_sdio += int'(sdio_oe); drv_sdo += int'(sdo_oe);
            end
            if (i >= 12 && i <= 27) rd_word = {rd_word[14:0], (sdo_oe ? sdo_out : sdio_out)};
            sclk = 1'b1;
            if (i == toggle_at) pin_mode = ~pin_mode;
            for (int k = 0; k < HALF; k++) begin
                @(negedge clk);
                drv_sdio += int'(sdio_oe); drv_sdo += int'(sdo_oe);
            end
            sclk = 1'b0;
        end
        for (int k = 0; k < HALF; k++) begin
            @(negedge clk);
            drv_sdio += int'(sdio_oe); drv_sdo += int'(sdo_oe);
        end
        en_n = 1'b1; sdi = 1'b0;
        repeat (3 * HALF) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] dev, input logic [6:0] ra, input logic [15:0] wd);
        xfer(1'b0, dev, ra, wd, 26, 0);
    endtask

    task automatic rd(input logic [1:0] dev, input logic [6:0] ra);
        xfer(1'b1, dev, ra, 16'h0, 27, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [2:0] er;
        int unsigned seed;
        rst_n = 0; en_n = 1; sclk = 0; sdi = 0; pin_enable = 0; pin_mode = 0; strap = STRAP;
        for (int a = 1; a <= 7; a++) model[a] = '0;
        seed = $urandom(32'd2024);
        repeat (4) @(negedge clk);
        // R9 reset state
        chk("R9 sdio_oe in reset", int'(sdio_oe), 0);
        chk("R9 routing in reset", int'({chip_en, mix1, mix2, bank, gpo_oe}), 0);
        rst_n = 1;
        repeat (10) @(negedge clk);

        // R2 read control with a foreign device address, addressing off
        rd(2'd3, 7'd0);
        chk("R2 ctrl read value", int'(rd_word), 0);
        chk("R5 sdio driven when accepted", int'(drv_sdio > 0), 1);
        chk("R4 sdo quiet in three-wire", drv_sdo, 0);

        // R2/R1 write from a foreign device address is accepted
        wr(2'd1, 7'd3, 16'hA5C3); model[3] = 16'hA5C3;
        rd(2'd0, 7'd3);
        chk("R2 write accepted before addressing", int'(rd_word), 16'hA5C3);

        // R10 out-of-range address
        wr(2'd2, 7'd12, 16'h1234);
        rd(2'd2, 7'd12);
        chk("R10 unmapped reads zero", int'(rd_word), 0);
        wr(2'd2, 7'd0, 16'hFF00);
        rd(2'd2, 7'd0);
        chk("R10 ctrl upper byte zero", int'(rd_word), 0);

        // R11 truncated frame
        xfer(1'b0, 2'd2, 7'd4, 16'hBEEF, 20, 0);
        rd(2'd2, 7'd4);
        chk("R11 short frame ignored", int'(rd_word), 0);

        // R3 enable addressing
        wr(2'd0, 7'd0, 16'h0004);
        wr(2'd0, 7'd5, 16'h7777);
        rd(STRAP, 7'd5);
        chk("R3 foreign write ignored", int'(rd_word), 0);
        rd(2'd1, 7'd3);
        chk("R3 foreign read no sdio drive", drv_sdio, 0);
        chk("R3 foreign read no sdo drive", drv_sdo, 0);
        wr(STRAP, 7'd5, 16'h5A5A); model[5] = 16'h5A5A;
        rd(STRAP, 7'd5);
        chk("R3 own write accepted", int'(rd_word), 16'h5A5A);

        // R3/R1 constrained random writes from all device addresses
        for (int n = 0; n < 60; n++) begin
            logic [1:0]  d;
            logic [6:0]  a;
            logic [15:0] v;
            d = 2'($urandom_range(0, 3));
            a = 7'($urandom_range(1, 7));
            v = 16'($urandom);
            wr(d, a, v);
            if (d == STRAP) model[a] = v;
        end
        for (int a = 1; a <= 7; a++) begin
            rd(STRAP, 7'(a));
            chk("R3 random readback", int'(rd_word), int'(model[a]));
        end

        // R4 four-wire
        wr(STRAP, 7'd0, 16'h0005);
        rd(STRAP, 7'd3);
        chk("R4 four-wire data", int'(rd_word), int'(model[3]));
        chk("R4 sdio never driven", drv_sdio, 0);
        chk("R4 sdo driven", int'(drv_sdo > 0), 1);
        wr(STRAP, 7'd0, 16'h0004);

        // R7/R8 routing from pins and duplex bit
        for (int dup = 0; dup < 2; dup++) begin
            for (int m = 0; m < 2; m++) begin
                wr(STRAP, 7'd0, 16'(dup ? 16'h0024 : 16'h0004));
                pin_mode = 1'(m);
                repeat (10) @(negedge clk);
                er = exp_route(1'(m), 1'(dup));
                chk(dup ? "R8 duplex routing" : "R7 simplex routing", int'({mix1, mix2, bank}), int'(er));
            end
        end

        // R8 same-edge: duplex write commits while mode pin flips
        pin_mode = 1'b0;
        wr(STRAP, 7'd0, 16'h0004);
        xfer(1'b0, STRAP, 7'd0, 16'h0024, 26, 26);
        repeat (10) @(negedge clk);
        chk("R8 concurrent write and pin flip", int'({mix1, mix2, bank}), int'(exp_route(1'b1, 1'b1)));
        chk("R6 pin enable follows", int'(chip_en), 0);

        // R6 software control
        pin_mode = 1'b0; pin_enable = 1'b0;
        wr(STRAP, 7'd0, 16'h005E); // gpo_en=1, sw_mode=1, sw_enable=1, addr_en, sw_ctrl
        repeat (10) @(negedge clk);
        chk("R6 sw chip enable", int'(chip_en), 1);
        chk("R6 sw mode routing", int'({mix1, mix2, bank}), int'(exp_route(1'b1, 1'b0)));
        chk("R6 gpo outputs", int'({gpo_oe, gpo_en_pin, gpo_mode_pin}), 3'b110);
        pin_mode = 1'b1; pin_enable = 1'b1;
        repeat (10) @(negedge clk);
        pin_mode = 1'b0; pin_enable = 1'b0;
        repeat (10) @(negedge clk);
        chk("R6 pins ignored", int'({chip_en, mix1, mix2, bank}), 4'b1011);

        // R9 reset mid-run
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R9 outputs cleared", int'({chip_en, gpo_oe, sdio_oe, sdo_oe}), 0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        rd(2'd1, 7'd0);
        chk("R9 ctrl cleared", int'(rd_word), 0);
        rd(2'd3, 7'd3);
        chk("R9 generic cleared", int'(rd_word), 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule